// File: doc/BRIEF.md
# Request-Acknowledge Register Access Master

This block lives on the host side of a streaming port and carries out one 32-bit register access at a time towards an external target. The host offers a command (address, read-not-write flag, four byte-lane enables and write data). When the block is idle it takes the command and raises a request towards the target. The request and every field that goes with it stay unchanged until the target answers with an acknowledge. The target sets the pace: the block has no timeout. The acknowledge ends the access. The request falls on the next clock, read data is captured from the target, and a one-cycle completion pulse goes back to the host.

The target can also signal an event with a single-clock interrupt pulse. The pulse sets a sticky status bit. The bit stays set until the host clears it by writing a one. If the host has set the interrupt enable, the status bit drives an interrupt line towards the processor.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so internal state leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `mmio_req_master`

## Requirements
- R1: While reset is asserted, `tgt_req`, `busy`, `done`, `irq_status`, `irq_en` and `irq_out` are all 0, and `cmd_ready` is 0.
- R2: A command offered with `cmd_valid`=1 while `busy`=0 is taken at that clock edge. From the next cycle, `tgt_req`=1 and `busy`=1, and `tgt_addr`, `tgt_rnw` and `tgt_be` carry the command's values. Bit i of `tgt_be` enables byte lane i, which is data bits 8i+7..8i.
- R3: A command offered while `busy`=1 is ignored. The target-side fields keep the values of the access in progress, and no second access follows the completion.
- R4: Once raised, `tgt_req` stays 1 with all target-side fields unchanged for every cycle in which `tgt_ack` is 0, whatever the wait length.
- R5: When `tgt_ack`=1 is sampled while `tgt_req`=1, `tgt_req` and `busy` are 0 in the next cycle and `done` is 1 for exactly that one cycle.
- R6: For a read (`tgt_rnw`=1), `rsp_rdata` takes the value of `tgt_rdata` sampled with the acknowledge. It holds that value through later writes until the next read completes.
- R7: For a write (`tgt_rnw`=0), `tgt_wdata` equals the command's write data for the whole access. During a read, `tgt_wdata` is all zeros.
- R8: An acknowledge that arrives while no request is outstanding has no effect: `done` stays 0 and `tgt_req` stays 0.
- R9: A one-cycle `tgt_int` pulse sets `irq_status` from the next cycle. The bit then stays 1 until `irq_clr`=1 is sampled, after which it reads 0.
- R10: When `tgt_int` and `irq_clr` are both 1 in the same cycle, `irq_status` stays 1.
- R11: `irq_en` loads `irq_en_val` on a cycle with `irq_en_wr`=1. `irq_out` is 1 exactly when `irq_status` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_addr | input | 16 | Command address |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_be | input | 4 | Byte-lane enables, bit i = lane i |
| cmd_wdata | input | 32 | Write data |
| cmd_ready | output | 1 | Block can take a command this cycle |
| busy | output | 1 | An access is outstanding |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Last read data captured |
| tgt_req | output | 1 | Request to target |
| tgt_addr | output | 16 | Address to target |
| tgt_rnw | output | 1 | Read-not-write to target |
| tgt_be | output | 4 | Byte-lane enables to target |
| tgt_wdata | output | 32 | Write data to target, zero on reads |
| tgt_rdata | input | 32 | Read data from target |
| tgt_ack | input | 1 | Target acknowledge |
| tgt_int | input | 1 | One-cycle interrupt pulse from target |
| irq_clr | input | 1 | Host write-one-to-clear of the status bit |
| irq_en_wr | input | 1 | Load strobe for the interrupt enable |
| irq_en_val | input | 1 | Value loaded into the interrupt enable |
| irq_status | output | 1 | Sticky interrupt status |
| irq_en | output | 1 | Interrupt enable |
| irq_out | output | 1 | Masked interrupt to processor |

## Verification
The access path is swept over every combination of direction, all sixteen byte-lane patterns and acknowledge delays of zero to three cycles. Each access gets its own address and data, computed from its index. A wrong lane mapping, a field that moves during the wait, or a swapped capture would therefore show as a mismatch on that access alone. A competing command is offered during the wait, which separates a block that ignores it from one that reloads. Stray acknowledges arrive while the block is idle. The interrupt path is tried with a lone pulse, a lone clear, a pulse and clear in the same cycle, and the enable both off and on. These cases separate set-priority from clear-priority and masked from unmasked output.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  typedef enum logic [0:0] {
    ACC_IDLE = 1'b0,
    ACC_WAIT = 1'b1
  } acc_state_e;

endpackage

// File: rtl/mm_rst_sync.sv
module mm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mm_access_ctrl.sv
module mm_access_ctrl
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rnw,
  input  logic [LANES-1:0]  cmd_be,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tgt_req,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              tgt_rnw,
  output logic [LANES-1:0]  tgt_be,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic              tgt_ack
);

  acc_state_e        state_q, state_d;
  logic              load_en;
  logic              finish;
  logic              capture_en;
  logic [ADDR_W-1:0] addr_q;
  logic              rnw_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    load_en    = 1'b0;
    finish     = 1'b0;
    unique case (state_q)
      ACC_IDLE: begin
        if (cmd_valid) begin
          load_en = 1'b1;
          state_d = ACC_WAIT;
        end
      end
      ACC_WAIT: begin
        if (tgt_ack) begin
          finish  = 1'b1;
          state_d = ACC_IDLE;
        end
      end
      default: state_d = ACC_IDLE;
    endcase
  end

  assign capture_en = finish && rnw_q;
  assign wdata_d    = cmd_rnw ? '0 : cmd_wdata;

  // state and done registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACC_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  // command field registers, loaded on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rnw_q   <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      addr_q  <= cmd_addr;
      rnw_q   <= cmd_rnw;
      be_q    <= cmd_be;
      wdata_q <= wdata_d;
    end
  end

  // read data capture, loaded on a read acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_en) begin
      rdata_q <= tgt_rdata;
    end
  end

  assign tgt_req   = (state_q == ACC_WAIT);
  assign busy      = tgt_req;
  assign cmd_ready = rst_n && (state_q == ACC_IDLE);
  assign done      = done_q;
  assign rsp_rdata = rdata_q;
  assign tgt_addr  = addr_q;
  assign tgt_rnw   = rnw_q;
  assign tgt_be    = be_q;
  assign tgt_wdata = wdata_q;

endmodule

// File: rtl/mm_irq_status.sv
module mm_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_pulse,
  input  logic en_wr,
  input  logic en_val,
  output logic status,
  output logic enable,
  output logic irq
);

  logic status_q, status_d;
  logic en_q;

  // set has priority over clear
  always_comb begin
    status_d = status_q;
    if (set_pulse) begin
      status_d = 1'b1;
    end else if (clr_pulse) begin
      status_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_wr) begin
      en_q <= en_val;
    end
  end

  assign status = status_q;
  assign enable = en_q;
  assign irq    = status_q & en_q;

endmodule

// File: rtl/mmio_req_master.sv
module mmio_req_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_rnw,
  input  logic [LANES-1:0]  cmd_be,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tgt_req,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              tgt_rnw,
  output logic [LANES-1:0]  tgt_be,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic              tgt_ack,
  input  logic              tgt_int,
  input  logic              irq_clr,
  input  logic              irq_en_wr,
  input  logic              irq_en_val,
  output logic              irq_status,
  output logic              irq_en,
  output logic              irq_out
);

  logic rst_n_int;

  mm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mm_access_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_rnw   (cmd_rnw),
    .cmd_be    (cmd_be),
    .cmd_wdata (cmd_wdata),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .rsp_rdata (rsp_rdata),
    .tgt_req   (tgt_req),
    .tgt_addr  (tgt_addr),
    .tgt_rnw   (tgt_rnw),
    .tgt_be    (tgt_be),
    .tgt_wdata (tgt_wdata),
    .tgt_rdata (tgt_rdata),
    .tgt_ack   (tgt_ack)
  );

  mm_irq_status u_irq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .set_pulse (tgt_int),
    .clr_pulse (irq_clr),
    .en_wr     (irq_en_wr),
    .en_val    (irq_en_val),
    .status    (irq_status),
    .enable    (irq_en),
    .irq       (irq_out)
  );

endmodule

// File: rtl/mmio_req_master_chk.sv
module mmio_req_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              tgt_req,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic              tgt_rnw,
  input logic [LANES-1:0]  tgt_be,
  input logic [DATA_W-1:0] tgt_wdata,
  input logic              tgt_ack,
  input logic              tgt_int,
  input logic              irq_clr,
  input logic              irq_status
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack) |=> tgt_req); // R4

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_ack) |=> ($stable(tgt_addr) && $stable(tgt_rnw)
                               && $stable(tgt_be) && $stable(tgt_wdata))); // R4

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !tgt_ack) |=> $stable(tgt_addr)); // R3

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_ack) |=> (!tgt_req && done)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_READ_WDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_rnw) |-> (tgt_wdata == '0)); // R7

  AST_IDLE_ACK_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_req && tgt_ack) |=> !done); // R8

  AST_INT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_int && irq_clr) |=> irq_status); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status && !irq_clr) |=> irq_status); // R9

endmodule

bind mmio_req_master mmio_req_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .busy       (busy),
  .done       (done),
  .tgt_req    (tgt_req),
  .tgt_addr   (tgt_addr),
  .tgt_rnw    (tgt_rnw),
  .tgt_be     (tgt_be),
  .tgt_wdata  (tgt_wdata),
  .tgt_ack    (tgt_ack),
  .tgt_int    (tgt_int),
  .irq_clr    (irq_clr),
  .irq_status (irq_status)
);

// File: tb/tb_mmio_req_master.sv
`timescale 1ns/1ps
module tb_mmio_req_master;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic          cmd_rnw;
  logic [BW-1:0] cmd_be;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_ready;
  logic          busy;
  logic          done;
  logic [DW-1:0] rsp_rdata;
  logic          tgt_req;
  logic [AW-1:0] tgt_addr;
  logic          tgt_rnw;
  logic [BW-1:0] tgt_be;
  logic [DW-1:0] tgt_wdata;
  logic [DW-1:0] tgt_rdata;
  logic          tgt_ack;
  logic          tgt_int;
  logic          irq_clr;
  logic          irq_en_wr;
  logic          irq_en_val;
  logic          irq_status;
  logic          irq_en;
  logic          irq_out;

  int n_vec;
  int n_bad;
  bit finished;
  logic [DW-1:0] last_rd;

  mmio_req_master #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // one access with a target wait of lat cycles; a competing command is offered while busy
  task automatic run_access(input int idx, input logic rnw, input logic [BW-1:0] be, input int lat);
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic [DW-1:0] rd;
    a  = AW'(16'h0400 + idx * 4);
    wd = 32'h5A000000 ^ (idx * 32'h00010203);
    rd = 32'hC3000000 ^ (idx * 32'h01020305);
    cmd_valid = 1'b1;
    cmd_addr  = a;
    cmd_rnw   = rnw;
    cmd_be    = be;
    cmd_wdata = wd;
    chk("R2 ready before accept", 32'(cmd_ready), 32'd1);
    tick;
    // competing command while busy
    cmd_addr  = ~a;
    cmd_rnw   = ~rnw;
    cmd_be    = ~be;
    cmd_wdata = ~wd;
    chk("R2 req raised", 32'(tgt_req), 32'd1);
    chk("R2 busy", 32'(busy), 32'd1);
    chk("R2 addr", 32'(tgt_addr), 32'(a));
    chk("R2 rnw", 32'(tgt_rnw), 32'(rnw));
    chk("R2 byte lanes", 32'(tgt_be), 32'(be));
    chk("R7 wdata", tgt_wdata, rnw ? 32'd0 : wd);
    for (int w = 0; w < lat; w++) begin
      tick;
      chk("R4 req held", 32'(tgt_req), 32'd1);
      chk("R3 addr unchanged", 32'(tgt_addr), 32'(a));
      chk("R3 be unchanged", 32'(tgt_be), 32'(be));
      chk("R4 wdata held", tgt_wdata, rnw ? 32'd0 : wd);
    end
    cmd_valid = 1'b0;
    tgt_ack   = 1'b1;
    tgt_rdata = rd;
    tick;
    tgt_ack   = 1'b0;
    tgt_rdata = 32'hDEADBEEF;
    if (rnw) last_rd = rd;
    chk("R5 req dropped", 32'(tgt_req), 32'd0);
    chk("R5 done pulse", 32'(done), 32'd1);
    chk("R6 read data", rsp_rdata, last_rd);
    tick;
    chk("R5 done one cycle", 32'(done), 32'd0);
    chk("R3 no second access", 32'(tgt_req), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_vec = 0; n_bad = 0; finished = 1'b0; last_rd = '0;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_rnw = 1'b0; cmd_be = '0; cmd_wdata = '0;
    tgt_rdata = '0; tgt_ack = 1'b0; tgt_int = 1'b0;
    irq_clr = 1'b0; irq_en_wr = 1'b0; irq_en_val = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req", 32'(tgt_req), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 ready", 32'(cmd_ready), 32'd0);
    chk("R1 status", 32'(irq_status), 32'd0);
    chk("R1 enable", 32'(irq_en), 32'd0);
    chk("R1 irq", 32'(irq_out), 32'd0);
    rst_n = 1'b1;
    repeat (3) tick;

    // R8: stray acknowledge while idle
    tgt_ack = 1'b1;
    tick;
    tgt_ack = 1'b0;
    chk("R8 idle ack no done", 32'(done), 32'd0);
    chk("R8 idle ack no req", 32'(tgt_req), 32'd0);

    // sweep direction x byte lanes x wait length
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 16; b++) begin
        for (int l = 0; l < 4; l++) begin
          run_access(r * 64 + b * 4 + l, r[0], b[3:0], l);
        end
      end
    end

    // stray acknowledge after traffic
    tgt_ack = 1'b1;
    tick;
    tgt_ack = 1'b0;
    chk("R8 late idle ack", 32'(done), 32'd0);
    chk("R6 read data held", rsp_rdata, last_rd);

    // interrupt: pulse with enable off
    tgt_int = 1'b1;
    tick;
    tgt_int = 1'b0;
    chk("R9 status set", 32'(irq_status), 32'd1);
    chk("R11 masked", 32'(irq_out), 32'd0);
    repeat (3) tick;
    chk("R9 status sticky", 32'(irq_status), 32'd1);
    irq_en_wr = 1'b1; irq_en_val = 1'b1;
    tick;
    irq_en_wr = 1'b0; irq_en_val = 1'b0;
    chk("R11 enable loaded", 32'(irq_en), 32'd1);
    chk("R11 irq out", 32'(irq_out), 32'd1);
    // pulse and clear together: set wins
    tgt_int = 1'b1; irq_clr = 1'b1;
    tick;
    tgt_int = 1'b0; irq_clr = 1'b0;
    chk("R10 set beats clear", 32'(irq_status), 32'd1);
    // clear alone
    irq_clr = 1'b1;
    tick;
    irq_clr = 1'b0;
    chk("R9 cleared", 32'(irq_status), 32'd0);
    chk("R11 irq low when clear", 32'(irq_out), 32'd0);
    // pulse and clear together from zero
    tgt_int = 1'b1; irq_clr = 1'b1;
    tick;
    tgt_int = 1'b0; irq_clr = 1'b0;
    chk("R10 set beats clear from zero", 32'(irq_status), 32'd1);
    // enable off masks again
    irq_en_wr = 1'b1; irq_en_val = 1'b0;
    tick;
    irq_en_wr = 1'b0;
    chk("R11 enable cleared", 32'(irq_en), 32'd0);
    chk("R11 masked again", 32'(irq_out), 32'd0);
    chk("R11 status kept", 32'(irq_status), 32'd1);

    tick;
    finish_run();
  end

endmodule